// File: doc/BRIEF.md
# Change-of-State Interrupt Controller

This block watches a bank of asynchronous digital lines, arranged as two groups of three 8-bit ports (A, B, C), and raises one interrupt request when something worth attention happens. Two kinds of event are caught. The first is any bit change on a port whose change detection is enabled, which sets a sticky change latch. The second is a qualified rising edge on bit 3 of port C in each group. That edge source counts only when the group's strap input is high, and only once software has touched one of the block's registers.

Software sees two write-side locations on a small register bus. The port-mask register sits at offset 0xB. The clear strobe sits at offset 0xF, and a write of any data there empties every latch. A read or write at either offset also arms the external edge sources. The single `irq` output is the OR of the change latch and the two external-edge latches.

Top module: `cos_irq_ctrl`

## Requirements
- R1: After reset `irq` is 0, the external edge sources are disarmed, and every mask bit is 0, so a change on any port is reported without a prior write.
- R2: Each `din` bit passes through two synchroniser flops. A change driven just before rising edge a shows on `irq` after edge a+2 and not before. No change is reported for the first three rising edges after reset release.
- R3: The mask register is written at offset 0xB from `reg_wdata[5:0]`. Bit 0 covers `din[7:0]` (group 0 port A), bit 1 covers `din[15:8]`, bit 2 covers `din[23:16]`, bit 3 covers `din[31:24]` (group 1 port A), bit 4 covers `din[39:32]` and bit 5 covers `din[47:40]`. A 1 masks that port's changes and a 0 lets them through.
- R4: Once set, the change latch holds `irq` high until a write of any data to offset 0xF.
- R5: If a change is detected on the same edge as a clear write, the change latch ends up set.
- R6: The external sources are `din[19]` for group 0 and `din[43]` for group 1. A source latches only if its synchronised line stays high for MIN_HIGH_CYC (default 4) consecutive samples after being low. It latches at most once per high period, and only while `strap_en[g]` is 1.
- R7: The external sources are armed by the first read or write at offset 0xB or 0xF. Accesses at any other offset do not arm them, and an edge counts only if its low-to-high transition is seen while armed.
- R8: A write to offset 0xF also clears both external-edge latches.
- R9: `irq` is high when the change latch or either external-edge latch is set.
- R10: An external line that is already high when the source becomes ready and armed does not latch. It must first be seen low.
- R11: Writes to offsets other than 0xB, and reads at any offset, leave the mask register unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| din | input | 48 | Asynchronous input lines, 8 bits per port, group 0 in the low half |
| strap_en | input | 2 | Per-group enable for the port C bit 3 edge source |
| reg_addr | input | 4 | Register offset |
| reg_wr | input | 1 | Write strobe |
| reg_rd | input | 1 | Read strobe; only arms the edge sources |
| reg_wdata | input | 8 | Write data |
| irq | output | 1 | Combined interrupt request |

## Verification
The bench aims a clear write at the very edge where a change is first detected. A design that lets the clear win there would lose that event. It raises an external line while the sources are still disarmed, then arms and clears before the qualification window ends. A design that counts from before arming, or that arms on a stray access at an unrelated offset, would latch that edge late. Pulses one sample shorter than the window and a line already high at reset are used to catch edge logic that fires on level or on too few samples. The bench also toggles one bit in each masked and unmasked port, so a mask-to-port mapping shifted by one position shows up as a missing or spurious request.

// File: rtl/cos_pkg.sv
package cos_pkg;
  localparam int unsigned GRP_DEF      = 2;
  localparam int unsigned PORTS_DEF    = 3;
  localparam int unsigned PORT_W_DEF   = 8;
  localparam int unsigned ADDR_W_DEF   = 4;
  localparam int unsigned DATA_W_DEF   = 8;
  localparam int unsigned MIN_HIGH_DEF = 4;
  localparam int unsigned EXT_BIT_DEF  = 3;
  localparam int unsigned PORTC_IDX    = 2;

  typedef enum logic [1:0] {
    ACC_NONE   = 2'd0,
    ACC_MASK   = 2'd1,
    ACC_CLEAR  = 2'd2
  } acc_kind_e;
endpackage

// File: rtl/cos_sync.sv
module cos_sync #(
  parameter int unsigned WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_async,
  output logic [WIDTH-1:0] d_sync
);
  logic [WIDTH-1:0] stg1_q;
  logic [WIDTH-1:0] stg2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stg1_q <= '0;
      stg2_q <= '0;
    end else begin
      stg1_q <= d_async;
      stg2_q <= stg1_q;
    end
  end

  assign d_sync = stg2_q;
endmodule

// File: rtl/cos_change_det.sv
module cos_change_det #(
  parameter int unsigned NPORT  = 6,
  parameter int unsigned PORT_W = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [NPORT*PORT_W-1:0] cur,
  output logic [NPORT-1:0]        port_chg,
  output logic                    ready
);
  localparam int unsigned LINES = NPORT * PORT_W;
  localparam logic [1:0]  WARM  = 2'd3;

  logic [LINES-1:0] prev_q;
  logic [1:0]       warm_q;
  logic [1:0]       warm_d;

  always_comb begin
    warm_d = warm_q;
    if (warm_q != WARM) warm_d = warm_q + 2'd1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      warm_q <= '0;
      prev_q <= '0;
    end else begin
      warm_q <= warm_d;
      prev_q <= cur;
    end
  end

  assign ready = (warm_q == WARM);

  for (genvar p = 0; p < NPORT; p++) begin : g_port
    assign port_chg[p] = ready &&
      (|(cur[p*PORT_W +: PORT_W] ^ prev_q[p*PORT_W +: PORT_W]));
  end

  AST_READY_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    ready |=> ready); // R2
endmodule

// File: rtl/cos_ext_edge.sv
module cos_ext_edge #(
  parameter int unsigned NGRP     = 2,
  parameter int unsigned MIN_HIGH = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NGRP-1:0] line,
  input  logic            run,
  output logic [NGRP-1:0] fire
);
  localparam int unsigned CW      = $clog2(MIN_HIGH + 1);
  localparam logic [CW-1:0] CNT_MAX = CW'(MIN_HIGH);
  localparam logic [CW-1:0] CNT_HIT = CW'(MIN_HIGH - 1);

  for (genvar g = 0; g < NGRP; g++) begin : g_grp
    logic [CW-1:0] cnt_q;
    logic [CW-1:0] cnt_d;

    always_comb begin
      if (!run)                cnt_d = CNT_MAX;
      else if (!line[g])       cnt_d = '0;
      else if (cnt_q < CNT_MAX) cnt_d = cnt_q + CW'(1);
      else                     cnt_d = cnt_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cnt_q <= CNT_MAX;
      else        cnt_q <= cnt_d;
    end

    assign fire[g] = run && line[g] && (cnt_q == CNT_HIT);

    AST_FIRE_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
      fire[g] |=> !fire[g]); // R6
  end
endmodule

// File: rtl/cos_irq_ctrl.sv
module cos_irq_ctrl
  import cos_pkg::*;
#(
  parameter int unsigned NUM_GRP       = GRP_DEF,
  parameter int unsigned PORTS_PER_GRP = PORTS_DEF,
  parameter int unsigned PORT_W        = PORT_W_DEF,
  parameter int unsigned ADDR_W        = ADDR_W_DEF,
  parameter int unsigned DATA_W        = DATA_W_DEF,
  parameter logic [ADDR_W-1:0] MASK_OFS  = ADDR_W'(4'hB),
  parameter logic [ADDR_W-1:0] CLEAR_OFS = ADDR_W'(4'hF),
  parameter int unsigned EXT_BIT       = EXT_BIT_DEF,
  parameter int unsigned MIN_HIGH_CYC  = MIN_HIGH_DEF
) (
  input  logic                                 clk,
  input  logic                                 rst_n,
  input  logic [NUM_GRP*PORTS_PER_GRP*PORT_W-1:0] din,
  input  logic [NUM_GRP-1:0]                   strap_en,
  input  logic [ADDR_W-1:0]                    reg_addr,
  input  logic                                 reg_wr,
  input  logic                                 reg_rd,
  input  logic [DATA_W-1:0]                    reg_wdata,
  output logic                                 irq
);
  localparam int unsigned NPORT = NUM_GRP * PORTS_PER_GRP;
  localparam int unsigned LINES = NPORT * PORT_W;
  localparam int unsigned GRP_W = PORTS_PER_GRP * PORT_W;

  logic [LINES-1:0]   din_s;
  logic [NPORT-1:0]   port_chg;
  logic               ready;
  logic [NUM_GRP-1:0] ext_line;
  logic [NUM_GRP-1:0] ext_fire;
  logic               ext_run;
  acc_kind_e          acc_kind;
  logic               mask_we;
  logic               clr;
  logic               hit;

  logic [NPORT-1:0]   mask_q,  mask_d;
  logic               armed_q, armed_d;
  logic               cos_q,   cos_d;
  logic [NUM_GRP-1:0] ext_q,   ext_d;

  cos_sync #(.WIDTH(LINES)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .d_async (din),
    .d_sync  (din_s)
  );

  cos_change_det #(.NPORT(NPORT), .PORT_W(PORT_W)) u_chg (
    .clk      (clk),
    .rst_n    (rst_n),
    .cur      (din_s),
    .port_chg (port_chg),
    .ready    (ready)
  );

  for (genvar g = 0; g < NUM_GRP; g++) begin : g_ext_tap
    assign ext_line[g] = din_s[g*GRP_W + PORTC_IDX*PORT_W + EXT_BIT];
  end

  assign ext_run = ready && armed_q;

  cos_ext_edge #(.NGRP(NUM_GRP), .MIN_HIGH(MIN_HIGH_CYC)) u_ext (
    .clk   (clk),
    .rst_n (rst_n),
    .line  (ext_line),
    .run   (ext_run),
    .fire  (ext_fire)
  );

  always_comb begin
    acc_kind = ACC_NONE;
    if (reg_wr || reg_rd) begin
      if (reg_addr == MASK_OFS)       acc_kind = ACC_MASK;
      else if (reg_addr == CLEAR_OFS) acc_kind = ACC_CLEAR;
    end
  end

  assign mask_we = reg_wr && (acc_kind == ACC_MASK);
  assign clr     = reg_wr && (acc_kind == ACC_CLEAR);
  assign hit     = |(port_chg & ~mask_q);

  always_comb begin
    mask_d  = mask_q;
    if (mask_we) mask_d = reg_wdata[NPORT-1:0];
    armed_d = armed_q || (acc_kind != ACC_NONE);
    cos_d   = hit || (cos_q && !clr);
    ext_d   = (ext_fire & strap_en) | (ext_q & {NUM_GRP{!clr}});
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q  <= '0;
      armed_q <= 1'b0;
      cos_q   <= 1'b0;
      ext_q   <= '0;
    end else begin
      mask_q  <= mask_d;
      armed_q <= armed_d;
      cos_q   <= cos_d;
      ext_q   <= ext_d;
    end
  end

  assign irq = cos_q || (|ext_q);

  AST_COS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (cos_q && !(reg_wr && reg_addr == CLEAR_OFS)) |=> cos_q); // R4
  AST_CLEAR_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == CLEAR_OFS && !hit) |=> !cos_q); // R4
  AST_CLEAR_LOSES: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == CLEAR_OFS && hit) |=> cos_q); // R5
  AST_MASKED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (!cos_q && ((port_chg & ~mask_q) == '0)) |=> !cos_q); // R3
  AST_MASK_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_wr && reg_addr == MASK_OFS) |=> $stable(mask_q)); // R11
  AST_ARM_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    armed_q |=> armed_q); // R7
  AST_FIRE_NEEDS_ARM: assert property (@(posedge clk) disable iff (!rst_n)
    (|ext_fire) |-> armed_q); // R7
  AST_WARMUP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (!ready && !cos_q) |=> !cos_q); // R2
  AST_CLEAR_DROPS_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == CLEAR_OFS && !hit && ((ext_fire & strap_en) == '0))
      |=> !irq); // R8

  for (genvar g = 0; g < NUM_GRP; g++) begin : g_strap_chk
    AST_STRAP_GATES: assert property (@(posedge clk) disable iff (!rst_n)
      (!strap_en[g] && !ext_q[g]) |=> !ext_q[g]); // R6
  end
endmodule

// File: tb/sim_cos_irq_ctrl.sv
module sim_cos_irq_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int MIN_HIGH   = 4;
  localparam int LINES      = 48;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic [LINES-1:0] din = '0;
  logic [1:0]       strap_en = 2'b11;
  logic [3:0]       reg_addr = '0;
  logic             reg_wr = 1'b0;
  logic             reg_rd = 1'b0;
  logic [7:0]       reg_wdata = '0;
  logic             irq;

  int    n_chk = 0;
  int    n_err = 0;
  bit    done  = 1'b0;
  string cur_req = "R1";

  cos_irq_ctrl u0 (
    .clk       (clk),
    .rst_n     (rst_n),
    .din       (din),
    .strap_en  (strap_en),
    .reg_addr  (reg_addr),
    .reg_wr    (reg_wr),
    .reg_rd    (reg_rd),
    .reg_wdata (reg_wdata),
    .irq       (irq)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // Behavioural reference: history of sampled inputs and event state.
  logic [LINES-1:0] hist [$];
  int   edges_m = 0;
  bit [5:0] mask_m = '0;
  bit   armed_m = 1'b0;
  bit   cos_m = 1'b0;
  bit [1:0] ext_m = '0;
  int   run_len [2] = '{MIN_HIGH, MIN_HIGH};

  initial begin
    hist.push_back('0); hist.push_back('0); hist.push_back('0);
  end

  always @(posedge clk) begin
    if (!rst_n) begin
      hist = {};
      hist.push_back('0); hist.push_back('0); hist.push_back('0);
      edges_m = 0; mask_m = '0; armed_m = 1'b0; cos_m = 1'b0; ext_m = '0;
      run_len[0] = MIN_HIGH; run_len[1] = MIN_HIGH;
    end else begin
      logic [LINES-1:0] now_v, old_v;
      bit rdy, any, clear_w, go;
      bit [1:0] new_ext;
      if (edges_m < 100) edges_m++;
      rdy   = (edges_m >= 4);
      now_v = hist[1];
      old_v = hist[2];
      any = 1'b0;
      for (int p = 0; p < 6; p++)
        if (rdy && !mask_m[p] && ((now_v[p*8 +: 8] ^ old_v[p*8 +: 8]) != 8'h00)) any = 1'b1;
      clear_w = reg_wr && (reg_addr == 4'hF);
      go = rdy && armed_m;
      for (int g = 0; g < 2; g++) begin
        bit lv, f;
        lv = now_v[g*24 + 19];
        f = 1'b0;
        if (!go) run_len[g] = MIN_HIGH;
        else if (!lv) run_len[g] = 0;
        else begin
          if (run_len[g] == MIN_HIGH - 1) f = 1'b1;
          if (run_len[g] < MIN_HIGH) run_len[g]++;
        end
        new_ext[g] = (f && strap_en[g]) || (ext_m[g] && !clear_w);
      end
      cos_m = any || (cos_m && !clear_w);
      ext_m = new_ext;
      if (reg_wr && reg_addr == 4'hB) mask_m = reg_wdata[5:0];
      if ((reg_wr || reg_rd) && (reg_addr == 4'hB || reg_addr == 4'hF)) armed_m = 1'b1;
      void'(hist.pop_back());
      hist.push_front(din);
    end
  end

  task automatic check(input logic act, input logic exp, input string req, input string what);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s: actual=%b expected=%b at %0t", req, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (!done) check(irq, cos_m || (|ext_m), cur_req, "model compare");

  task automatic tick(input int k);
    repeat (k) @(negedge clk);
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a);
    reg_addr = a; reg_rd = 1'b1;
    @(negedge clk);
    reg_rd = 1'b0;
  endtask

  task automatic finish_run;
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL %s watchdog: actual=timeout expected=completion", cur_req);
      finish_run();
    end
  end

  initial begin
    din[19] = 1'b1;                       // external line high through reset (R10)
    tick(3);
    rst_n = 1'b1;
    tick(6);
    cur_req = "R1";
    check(irq, 1'b0, "R1", "idle after reset");

    // R7: stray read does not arm; an edge seen before arming never latches.
    cur_req = "R7";
    rd(4'h3);
    din[19] = 1'b0; tick(5);
    din[19] = 1'b1; tick(3);
    check(irq, 1'b1, "R1", "port C change reported with reset mask");
    wr(4'hB, 8'h04);                      // arms, masks group 0 port C
    wr(4'hF, 8'h00);
    tick(8);
    check(irq, 1'b0, "R7", "edge from before arming ignored");
    cur_req = "R10";
    tick(6);
    check(irq, 1'b0, "R10", "line already high does not latch");

    // R6: qualified edge, group 0.
    cur_req = "R6";
    din[19] = 1'b0; tick(4);
    din[19] = 1'b1; tick(5);
    check(irq, 1'b0, "R6", "one sample before window ends");
    tick(1);
    check(irq, 1'b1, "R9", "external latch alone drives irq");
    cur_req = "R8";
    wr(4'hF, 8'h3C);
    check(irq, 1'b0, "R8", "clear empties external latch");
    cur_req = "R6";
    din[19] = 1'b0; tick(4);
    din[19] = 1'b1; tick(3);
    din[19] = 1'b0; tick(8);
    check(irq, 1'b0, "R6", "short pulse rejected");

    // R6: strap gating on group 1.
    strap_en[1] = 1'b0;
    wr(4'hB, 8'h24);
    din[43] = 1'b1; tick(10);
    check(irq, 1'b0, "R6", "strap low blocks group 1");
    din[43] = 1'b0; tick(3);
    strap_en[1] = 1'b1;
    din[43] = 1'b1; tick(10);
    check(irq, 1'b1, "R6", "strap high passes group 1");
    cur_req = "R8";
    wr(4'hF, 8'h00);
    check(irq, 1'b0, "R8", "clear empties group 1 latch");
    din[43] = 1'b0; tick(4);

    // R2: latency through synchroniser.
    cur_req = "R2";
    wr(4'hB, 8'h00);
    din[2] = ~din[2]; tick(2);
    check(irq, 1'b0, "R2", "not yet visible after two edges");
    tick(1);
    check(irq, 1'b1, "R2", "visible after third edge");
    cur_req = "R4";
    tick(10);
    check(irq, 1'b1, "R4", "latch holds");
    wr(4'hF, 8'hFF);
    check(irq, 1'b0, "R4", "clear write drops latch");

    // R3: mask mapping.
    cur_req = "R3";
    wr(4'hB, 8'h01);
    din[0] = ~din[0]; tick(5);
    check(irq, 1'b0, "R3", "group 0 port A masked by bit 0");
    din[8] = ~din[8]; tick(5);
    check(irq, 1'b1, "R3", "group 0 port B unmasked");
    wr(4'hF, 8'h00);
    wr(4'hB, 8'h1F);
    din[31] = ~din[31]; tick(5);
    check(irq, 1'b0, "R3", "group 1 port A masked by bit 3");
    din[45] = ~din[45]; tick(5);
    check(irq, 1'b1, "R3", "group 1 port C unmasked by bit 5");
    wr(4'hF, 8'h00);
    check(irq, 1'b0, "R3", "cleared");

    // R11: other offsets and reads leave the mask alone.
    cur_req = "R11";
    wr(4'h3, 8'h00);
    rd(4'hB);
    din[31] = ~din[31]; tick(5);
    check(irq, 1'b0, "R11", "mask unchanged by foreign write");

    // R5: clear on the detection edge.
    cur_req = "R5";
    wr(4'hB, 8'h00);
    din[47] = ~din[47]; tick(2);
    wr(4'hF, 8'hA5);
    check(irq, 1'b1, "R5", "change on clear edge survives");
    wr(4'hF, 8'h00);
    check(irq, 1'b0, "R5", "second clear empties");

    // R9: both sources together.
    cur_req = "R9";
    din[19] = 1'b0; tick(6);
    din[19] = 1'b1; tick(8);
    check(irq, 1'b1, "R9", "change and edge together");
    wr(4'hF, 8'h00);
    check(irq, 1'b0, "R9", "all latches cleared");

    // Mixed traffic against the model.
    cur_req = "R2";
    for (int i = 0; i < 400; i++) begin
      int r;
      r = $urandom_range(0, 15);
      if (r < 3) din[$urandom_range(0, 47)] ^= 1'b1;
      if (r == 4) din[19] ^= 1'b1;
      if (r == 5) din[43] ^= 1'b1;
      if (r == 6) wr(4'hB, 8'($urandom_range(0, 63)));
      else if (r == 7) wr(4'hF, 8'h00);
      else tick(1);
    end
    tick(4);
    finish_run();
  end
endmodule